// File: doc/BRIEF.md
# Eight-Level Prioritized Interrupt Arbiter

This block sits beside a small stack-based processor core and decides which of eight prioritized interrupt levels, if any, should break into the running program. It keeps two one-bit-per-level registers. The pending register collects requests as they arrive. The in-service register records the levels whose handlers are currently running. Level 7 is the most urgent and level 0 the least. Requests come from peripheral lines and from a software request port driven by the core. They are sampled at each instruction-cycle boundary, except during cycles that the core marks as I/O cycles.

The block offers an interrupt to the core when three conditions hold: the global enable is high, something is pending, and the highest pending level is strictly above every level in service. This lets a more urgent handler nest inside a less urgent one. The offer is a valid/ready pair carrying the handler vector and the level index. On the handshake, the winning level moves from pending to in-service; the core then saves its program counter and calls the vector. A return pulse from the core retires the most urgent level in service, which opens arbitration to lower levels again.

Back-pressure rules for the offer are as follows. A transfer takes place in any cycle in which both `irq_valid_o` and `ack_ready_i` are high. While ready stays low, the offer is not held stable. It may be withdrawn because the enable has dropped, or it may be retargeted to a more urgent level that has just arrived. The core must therefore use `vec_o` and `lvl_o` as seen in the handshake cycle. Ready with no valid has no effect.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears both the pending and the in-service registers, so `irq_valid_o` is low after reset.
- R2: In a cycle with `cyc_i` high and `io_cyc_i` low, every set bit of `req_i` sets the matching pending bit at the next clock edge. Pending bits stay set until that level is acknowledged.
- R3: In a cycle with `io_cyc_i` high or `cyc_i` low, no request of any source is latched, and the pending register does not change unless a handshake occurs.
- R4: A software request (`sw_req_i` high with level `sw_lvl_i`) sets pending bit `sw_lvl_i` under the same sampling rule as the request lines.
- R5: The winner is the highest-numbered set pending bit. `lvl_o` gives its index, and `vec_o` = 0x040 + 8 × level (default parameters; for example, level 3 gives 0x058).
- R6: `irq_valid_o` is high only when `gie_i` is high, at least one bit is pending, and the winner level is strictly greater than the highest in-service level (or nothing is in service). A winner equal to the highest in-service level is not offered.
- R7: While `gie_i` is low, `irq_valid_o` stays low but requests are still latched. They are offered as soon as `gie_i` returns high.
- R8: On a handshake, the winner's pending bit is cleared and its in-service bit is set at the same clock edge. `ack_ready_i` without `irq_valid_o` changes neither register.
- R9: If a request for the winning level is sampled in the same cycle as its handshake, its pending bit stays set.
- R10: A `reti_i` pulse clears only the highest set in-service bit. With nothing in service, it has no effect.
- R11: A level above the highest in-service level is offered and taken while a lower level is in service (nesting). After the nested level retires, lower pending levels become eligible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Instruction-cycle boundary strobe |
| io_cyc_i | input | 1 | Current cycle is an I/O instruction; suppresses sampling |
| req_i | input | 8 | Peripheral request lines, one per level |
| sw_req_i | input | 1 | Software request strobe from the core |
| sw_lvl_i | input | 3 | Level of the software request |
| gie_i | input | 1 | Global interrupt enable |
| irq_valid_o | output | 1 | Interrupt offered to the core |
| ack_ready_i | input | 1 | Core accepts the offer (acknowledge cycle) |
| vec_o | output | 12 | Handler vector of the winning level |
| lvl_o | output | 3 | Index of the winning level |
| reti_i | input | 1 | Return-from-interrupt pulse |
| pend_o | output | 8 | Pending register |
| act_o | output | 8 | In-service register |

## Verification
The assertions watch, on every cycle, the rules that relate neighbouring cycles. The enable blocks the offer. The offered level is the top pending bit and sits above the top in-service bit. Pending bits never drop without a handshake and never change in a non-sampling cycle. A handshake sets the in-service bit of the level it took, and a return drops exactly one in-service bit. Only the bench's scenarios can show the values themselves: the vector numbers, the software request reaching the right level, the collision of a request with its own handshake, and a full nest-and-unwind sequence in which a lower level becomes eligible again.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned DEF_LEVELS  = 8;
  localparam int unsigned DEF_VEC_W   = 12;
  localparam int unsigned DEF_VBASE   = 32'h40;
  localparam int unsigned DEF_VSTRIDE = 8;

  // per-cycle control strobes derived at the top
  typedef struct packed {
    logic sample;   // latch requests this cycle
    logic take;     // handshake with the core
    logic retire;   // return from handler
  } irq_ctl_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N  = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] bits_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = |bits_i;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (bits_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned N  = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample_i,
  input  logic [N-1:0] req_i,
  input  logic         sw_req_i,
  input  logic [W-1:0] sw_lvl_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_lvl_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] sw_hot, set_m, clr_m;

  always_comb begin
    sw_hot = sw_req_i ? (N'(1) << sw_lvl_i) : '0;
    set_m  = sample_i ? (req_i | sw_hot) : '0;
    clr_m  = clr_i ? (N'(1) << clr_lvl_i) : '0;
  end

  // a fresh sample of the same level beats the clear
  always_ff @(posedge clk) begin
    if (rst) pend_o <= '0;
    else     pend_o <= (pend_o & ~clr_m) | set_m;
  end
endmodule

// File: rtl/irq_act_reg.sv
module irq_act_reg #(
  parameter int unsigned N  = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_i,
  input  logic [W-1:0] set_lvl_i,
  input  logic         ret_i,
  output logic [N-1:0] act_o,
  output logic         any_o,
  output logic [W-1:0] top_o
);
  logic [N-1:0] set_m, ret_m;

  irq_prio_enc #(.N(N)) u_top (
    .bits_i(act_o),
    .any_o (any_o),
    .idx_o (top_o)
  );

  always_comb begin
    set_m = set_i ? (N'(1) << set_lvl_i) : '0;
    ret_m = (ret_i && any_o) ? (N'(1) << top_o) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) act_o <= '0;
    else     act_o <= (act_o & ~ret_m) | set_m;
  end
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
  parameter int unsigned N      = 8,
  parameter int unsigned VW     = 12,
  parameter int unsigned BASE   = 32'h40,
  parameter int unsigned STRIDE = 8,
  localparam int unsigned W     = $clog2(N)
) (
  input  logic [W-1:0]  lvl_i,
  output logic [VW-1:0] vec_o
);
  logic [VW-1:0] tbl [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign tbl[g] = VW'(BASE + g * STRIDE);
  end

  assign vec_o = tbl[lvl_i];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = DEF_LEVELS,
  parameter int unsigned VEC_W      = DEF_VEC_W,
  parameter int unsigned VEC_BASE   = DEF_VBASE,
  parameter int unsigned VEC_STRIDE = DEF_VSTRIDE,
  localparam int unsigned LW        = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cyc_i,
  input  logic                  io_cyc_i,
  input  logic [NUM_LEVELS-1:0] req_i,
  input  logic                  sw_req_i,
  input  logic [LW-1:0]         sw_lvl_i,
  input  logic                  gie_i,
  output logic                  irq_valid_o,
  input  logic                  ack_ready_i,
  output logic [VEC_W-1:0]      vec_o,
  output logic [LW-1:0]         lvl_o,
  input  logic                  reti_i,
  output logic [NUM_LEVELS-1:0] pend_o,
  output logic [NUM_LEVELS-1:0] act_o
);
  irq_ctl_t      ctl;
  logic          pend_any, act_any;
  logic [LW-1:0] win_lvl, act_top;
  logic          outranks;

  irq_prio_enc #(.N(NUM_LEVELS)) u_win (
    .bits_i(pend_o),
    .any_o (pend_any),
    .idx_o (win_lvl)
  );

  // strictly above the most urgent level in service
  assign outranks    = !act_any || (win_lvl > act_top);
  assign irq_valid_o = gie_i && pend_any && outranks;

  always_comb begin
    ctl.sample = cyc_i && !io_cyc_i;
    ctl.take   = irq_valid_o && ack_ready_i;
    ctl.retire = reti_i;
  end

  irq_pend_reg #(.N(NUM_LEVELS)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .sample_i (ctl.sample),
    .req_i    (req_i),
    .sw_req_i (sw_req_i),
    .sw_lvl_i (sw_lvl_i),
    .clr_i    (ctl.take),
    .clr_lvl_i(win_lvl),
    .pend_o   (pend_o)
  );

  irq_act_reg #(.N(NUM_LEVELS)) u_act (
    .clk      (clk),
    .rst      (rst),
    .set_i    (ctl.take),
    .set_lvl_i(win_lvl),
    .ret_i    (ctl.retire),
    .act_o    (act_o),
    .any_o    (act_any),
    .top_o    (act_top)
  );

  irq_vec_map #(
    .N(NUM_LEVELS), .VW(VEC_W), .BASE(VEC_BASE), .STRIDE(VEC_STRIDE)
  ) u_vec (
    .lvl_i(win_lvl),
    .vec_o(vec_o)
  );

  assign lvl_o = win_lvl;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned NUM_LEVELS = 8,
  localparam int unsigned LW        = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cyc_i,
  input logic                  io_cyc_i,
  input logic                  gie_i,
  input logic                  ack_ready_i,
  input logic                  reti_i,
  input logic                  irq_valid_o,
  input logic [LW-1:0]         lvl_o,
  input logic [NUM_LEVELS-1:0] pend_o,
  input logic [NUM_LEVELS-1:0] act_o
);
  function automatic int top_of(logic [NUM_LEVELS-1:0] v);
    int r = -1;
    for (int i = 0; i < NUM_LEVELS; i++) if (v[i]) r = i;
    return r;
  endfunction

  logic hs;
  assign hs = irq_valid_o && ack_ready_i;

  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (pend_o == '0 && act_o == '0)); // R1
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst) !hs |=> (($past(pend_o) & ~pend_o) == '0)); // R2
  AST_NO_SAMPLE: assert property (@(posedge clk) disable iff (rst) ((io_cyc_i || !cyc_i) && !hs) |=> (pend_o == $past(pend_o))); // R3
  AST_WIN_TOP: assert property (@(posedge clk) disable iff (rst) irq_valid_o |-> (top_of(pend_o) == int'(lvl_o))); // R5
  AST_OUTRANKS: assert property (@(posedge clk) disable iff (rst) irq_valid_o |-> (int'(lvl_o) > top_of(act_o))); // R6
  AST_GIE_GATE: assert property (@(posedge clk) disable iff (rst) !gie_i |-> !irq_valid_o); // R7
  AST_TAKE_SETS: assert property (@(posedge clk) disable iff (rst) hs |=> act_o[$past(lvl_o)]); // R8
  AST_RETI_ONE: assert property (@(posedge clk) disable iff (rst) (reti_i && !hs) |=> ($countones(act_o) == $countones($past(act_o)) - (($past(act_o) != '0) ? 1 : 0))); // R10
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cyc_i      (cyc_i),
  .io_cyc_i   (io_cyc_i),
  .gie_i      (gie_i),
  .ack_ready_i(ack_ready_i),
  .reti_i     (reti_i),
  .irq_valid_o(irq_valid_o),
  .lvl_o      (lvl_o),
  .pend_o     (pend_o),
  .act_o      (act_o)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, cyc, io_cyc, sw_req, gie, ack_ready, reti;
  logic [7:0] req;
  logic [2:0] sw_lvl;
  logic       irq_valid;
  logic [11:0] vec;
  logic [2:0] lvl;
  logic [7:0] pend, act;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst(rst), .cyc_i(cyc), .io_cyc_i(io_cyc), .req_i(req),
    .sw_req_i(sw_req), .sw_lvl_i(sw_lvl), .gie_i(gie), .irq_valid_o(irq_valid),
    .ack_ready_i(ack_ready), .vec_o(vec), .lvl_o(lvl), .reti_i(reti),
    .pend_o(pend), .act_o(act)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step(); rst = 1'b0; step();
    chk("R1 pend after reset", pend, 8'h00);
    chk("R1 act after reset", act, 8'h00);
    chk("R1 valid after reset", irq_valid, 0);
  endtask

  task automatic t_sample();
    gie = 1'b0; cyc = 1'b1; req = 8'h05; step(); req = 8'h00;
    chk("R2 latch lines", pend, 8'h05);
    step();
    chk("R2 sticky", pend, 8'h05);
    chk("R7 gated while gie low", irq_valid, 0);
  endtask

  task automatic t_no_sample();
    io_cyc = 1'b1; req = 8'h80; step();
    chk("R3 io cycle ignored", pend, 8'h05);
    io_cyc = 1'b0; cyc = 1'b0; step();
    chk("R3 no cycle strobe ignored", pend, 8'h05);
    req = 8'h00; cyc = 1'b1;
  endtask

  task automatic t_sw();
    sw_req = 1'b1; sw_lvl = 3'd3; step(); sw_req = 1'b0;
    chk("R4 software level 3", pend, 8'h0D);
  endtask

  task automatic t_enable();
    gie = 1'b1; #1;
    chk("R7 offered after enable", irq_valid, 1);
    chk("R5 winner level", lvl, 3);
    chk("R5 vector level 3", vec, 12'h058);
  endtask

  task automatic t_idle_ready();
    gie = 1'b0; ack_ready = 1'b1; step(); ack_ready = 1'b0;
    chk("R8 ready without valid pend", pend, 8'h0D);
    chk("R8 ready without valid act", act, 8'h00);
  endtask

  task automatic t_take();
    gie = 1'b1; ack_ready = 1'b1; step(); ack_ready = 1'b0;
    chk("R8 pend cleared", pend, 8'h05);
    chk("R8 act set", act, 8'h08);
    chk("R6 lower not offered", irq_valid, 0);
  endtask

  task automatic t_nest();
    req = 8'h40; step(); req = 8'h00;
    chk("R11 higher offered", irq_valid, 1);
    chk("R5 vector level 6", vec, 12'h070);
    ack_ready = 1'b1; step(); ack_ready = 1'b0;
    chk("R11 nested act", act, 8'h48);
    chk("R11 nested pend", pend, 8'h05);
  endtask

  task automatic t_unwind();
    reti = 1'b1; step();
    chk("R10 top retired", act, 8'h08);
    step();
    chk("R10 second retire", act, 8'h00);
    chk("R11 lower eligible", irq_valid, 1);
    chk("R5 vector level 2", vec, 12'h050);
    step(); reti = 1'b0;
    chk("R10 empty retire act", act, 8'h00);
    chk("R10 empty retire pend", pend, 8'h05);
  endtask

  task automatic t_collide();
    req = 8'h04; ack_ready = 1'b1; step(); req = 8'h00; ack_ready = 1'b0;
    chk("R9 pend kept on collision", pend, 8'h05);
    chk("R9 act on collision", act, 8'h04);
    chk("R6 equal level blocked", irq_valid, 0);
  endtask

  initial begin
    rst = 1'b1; cyc = 1'b0; io_cyc = 1'b0; req = '0; sw_req = 1'b0;
    sw_lvl = '0; gie = 1'b0; ack_ready = 1'b0; reti = 1'b0;
    t_reset();
    t_sample();
    t_no_sample();
    t_sw();
    t_enable();
    t_idle_ready();
    t_take();
    t_nest();
    t_unwind();
    t_collide();
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 reset mid-run pend", pend, 8'h00);
    chk("R1 reset mid-run act", act, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule